// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses the direction of conditional branches. It keeps a table of two-bit saturating counters. A group of bits taken from the fetch PC selects one counter. The front end presents a fetch PC on the lookup port and gets back a taken or not-taken guess in the same cycle, with no register in between.

The retirement stage feeds the update port. When a conditional branch retires, the stage presents that branch's PC, its resolved direction and a valid strobe. At the next clock edge the selected counter moves one step toward the resolved direction. Branches retire in program order, so the counters learn in program order. If a lookup and an update select the same counter in one cycle, the lookup sees the value from before that edge.

Top module: `bimodal_predictor`

## Requirements
- R1: After reset all 512 counters hold 1, so every lookup predicts not taken (lookup output 0) until an update changes a counter.
- R2: The counter is selected by PC bits [11:3]. PCs that differ only in bits [2:0] or in bits above 11 share one counter. PCs that differ anywhere in [11:3] use separate counters.
- R3: A counter at 3 stays at 3 when a taken outcome is applied to it.
- R4: A counter at 0 stays at 0 when a not-taken outcome is applied to it.
- R5: The lookup output is 1 (taken) when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R6: A valid update with outcome 1 (taken) adds one to the selected counter. A valid update with outcome 0 subtracts one.
- R7: The lookup output depends combinationally on the lookup PC and is valid in the same cycle the PC is presented.
- R8: When a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle on.
- R9: While the update valid strobe is 0, no counter changes, whatever the update PC and outcome are.
- R10: Valid updates in consecutive cycles to the same counter each take effect, in order, and their effects add up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | The update fields are valid this cycle |
| upd_pc | input | 32 | PC of the retiring conditional branch |
| upd_outcome | input | 1 | Resolved direction, 1 = taken |

## Verification
The lookup result comes from combinational logic, so it is due in the same cycle the PC is presented. The bench drives inputs on the falling edge and samples the result one nanosecond later, before the next rising edge. An update takes effect at the rising edge that follows the cycle in which it is presented. The bench's reference model therefore applies each update only after that cycle's lookup has been checked. A lookup issued in the same cycle as an update is then compared against the value from before the update, and any later lookup against the new value.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_TOP = '1;
  localparam ctr_t CTR_BOT = '0;

  // Move one step toward the resolved direction, holding at the ends.
  function automatic ctr_t ctr_step(ctr_t c, logic went_taken);
    ctr_t r;
    if (went_taken) r = (c == CTR_TOP) ? c : c + ctr_t'(1);
    else            r = (c == CTR_BOT) ? c : c - ctr_t'(1);
    return r;
  endfunction

  // Upper half of the range means taken.
  function automatic logic ctr_says_taken(ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int LO    = 3,
  parameter int IDX_W = 9
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = IDX_W'(pc >> LO);
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int   IDX_W     = 9,
  parameter ctr_t RESET_CTR = ctr_t'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_val,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_val
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t cnt_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q[e] <= RESET_CTR;
      else if (hit) cnt_q[e] <= wr_val;
    end
  end

  assign rd_a_val = cnt_q[rd_a_idx];
  assign rd_b_val = cnt_q[rd_b_idx];
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 3,
  parameter int IDX_W  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_outcome
);
  localparam ctr_t RESET_CTR = ctr_t'(1);

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  ctr_t             lk_cnt;
  ctr_t             wr_old;
  ctr_t             wr_new;
  logic             upd_fire;

  bp_index #(.PC_W(PC_W), .LO(IDX_LO), .IDX_W(IDX_W)) u_lk_idx (
    .pc(lk_pc), .idx(lk_idx)
  );
  bp_index #(.PC_W(PC_W), .LO(IDX_LO), .IDX_W(IDX_W)) u_upd_idx (
    .pc(upd_pc), .idx(upd_idx)
  );

  assign upd_fire = upd_valid;
  assign wr_new   = ctr_step(wr_old, upd_outcome);

  bp_table #(.IDX_W(IDX_W), .RESET_CTR(RESET_CTR)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (upd_fire),
    .wr_idx  (upd_idx),
    .wr_val  (wr_new),
    .rd_a_idx(lk_idx),
    .rd_a_val(lk_cnt),
    .rd_b_idx(upd_idx),
    .rd_b_val(wr_old)
  );

  assign lk_taken = ctr_says_taken(lk_cnt);
endmodule

// File: rtl/bp_checker.sv
module bp_checker
  import bp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_fire,
  input logic             upd_outcome,
  input logic [IDX_W-1:0] upd_idx,
  input logic [IDX_W-1:0] lk_idx,
  input logic             lk_taken,
  input ctr_t             wr_old,
  input ctr_t             wr_new
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // First cycle out of reset: the counter on the update path holds the reset value.
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> wr_old == ctr_t'(1));

  // Two read paths that select the same entry agree in the same cycle.
  p_same_cycle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_idx == upd_idx) |-> lk_taken == wr_old[CTR_W-1]);

  // A stored update reads back on the following cycle.
  p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(upd_fire) && upd_idx == $past(upd_idx) |-> wr_old == $past(wr_new));

  // Saturation at the top.
  p_hold_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(upd_fire) && $past(upd_outcome) && $past(wr_old) == CTR_TOP
      && upd_idx == $past(upd_idx) |-> wr_old == CTR_TOP);

  // Saturation at the bottom.
  p_hold_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(upd_fire) && !$past(upd_outcome) && $past(wr_old) == CTR_BOT
      && upd_idx == $past(upd_idx) |-> wr_old == CTR_BOT);

  // No strobe, no change.
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(upd_fire) && upd_idx == $past(upd_idx) |-> wr_old == $past(wr_old));
endmodule

bind bimodal_predictor bp_checker #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_fire   (upd_fire),
  .upd_outcome(upd_outcome),
  .upd_idx    (upd_idx),
  .lk_idx     (lk_idx),
  .lk_taken   (lk_taken),
  .wr_old     (wr_old),
  .wr_new     (wr_new)
);

// File: tb/bimodal_predictor_test.sv
module bimodal_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_outcome = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int model [512];

  always #4 clk = ~clk;

  bimodal_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_outcome(upd_outcome)
  );

  function automatic int slot(logic [31:0] pc);
    return int'((pc / 8) % 512);
  endfunction

  function automatic int next_val(int c, bit t);
    if (t) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: lk_pc=%h actual=%0b expected=%0b", req, lk_pc, got, exp);
    end
  endtask

  // One cycle: drive at falling edge, check lookup before rising edge,
  // model update lands at that rising edge.
  task automatic step(string req, logic [31:0] lpc, bit v, logic [31:0] upc, bit o);
    @(negedge clk);
    lk_pc = lpc; upd_valid = v; upd_pc = upc; upd_outcome = o;
    #1;
    check(req, lk_taken, model[slot(lpc)] >= 2);
    if (v) model[slot(upc)] = next_val(model[slot(upc)], o);
  endtask

  task automatic peek(string req, logic [31:0] lpc, bit exp);
    @(negedge clk);
    lk_pc = lpc; upd_valid = 0;
    #1;
    check(req, lk_taken, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    for (int i = 0; i < 512; i++) model[i] = 1;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state, R7 same-cycle lookup
    peek("R1", 32'h0000_0000, 0);
    peek("R1", 32'h0000_0ff8, 0);
    peek("R7", 32'h1234_5678, 0);

    // R6 increment, R2 aliasing
    a = 32'h0000_0120;
    step("R6", a, 1, a, 1);
    peek("R6", a, 1);
    peek("R2", a + 32'd5, 1);
    peek("R2", a + 32'h1000, 1);
    peek("R2", a + 32'd8, 0);
    peek("R2", a - 32'd8, 0);

    // R3 saturation at top: 2 -> 3 -> 3 -> 3, then two decrements
    step("R10", a, 1, a, 1);
    step("R3", a, 1, a, 1);
    step("R3", a, 1, a, 1);
    step("R3", a, 1, a, 0);
    peek("R3", a, 1);
    step("R5", a, 1, a, 0);
    peek("R5", a, 0);

    // R4 saturation at bottom
    a = 32'h0000_0840;
    step("R6", a, 1, a, 0);
    step("R4", a, 1, a, 0);
    step("R4", a, 1, a, 0);
    step("R4", a, 1, a, 1);
    peek("R4", a, 0);
    step("R5", a, 1, a, 1);
    peek("R5", a, 1);

    // R8 read during write: same cycle sees old value
    a = 32'h0000_0a08;
    step("R8", a, 1, a, 1);
    peek("R8", a, 1);

    // R9 strobe low: nothing moves
    a = 32'h0000_0b10;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lk_pc = a; upd_valid = 0; upd_pc = a; upd_outcome = 1;
    end
    peek("R9", a, 0);

    // R10 back-to-back updates add up
    a = 32'h0000_0c18;
    step("R10", a, 1, a, 1);
    step("R10", a, 1, a, 1);
    step("R10", a, 1, a + 32'h2000, 1);
    peek("R10", a, 1);

    // random traffic over a small index range to force collisions
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] lp, up;
      lp = $urandom(); up = $urandom();
      lp[11:3] = 9'($urandom_range(0, 15));
      up[11:3] = ($urandom_range(0, 3) == 0) ? lp[11:3] : 9'($urandom_range(0, 15));
      step("R5", lp, $urandom_range(0, 3) != 0, up, 1'($urandom()));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule